// File: doc/BRIEF.md
# Reset Cause Controller

This block collects four reasons for resetting a chip: power-on, an external reset pin, a watchdog expiry and a request from software. It turns any of them into a system reset pulse of fixed length. It drives a second reset line for the watchdog domain, and only power-on asserts that line. A small register port lets software read which sources have fired since the flags were last cleared. Software can clear flags through a write-only clear register and can start a software reset by writing the status register.

Power-on is the block's own synchronous active-low reset input `rst_n`. The external and watchdog requests are single-cycle pulses that are already synchronous to `clk`. The register port has no wait states. A write takes effect at the clock edge where `reg_we` is high. Reads are combinational from `reg_addr`.

The cause flags are 4 bits. Bit 0 is power-on, bit 1 is watchdog, bit 2 is software and bit 3 is external. They read back in bits 3..0 of the status register at offset 0x230. The clear register sits at offset 0x234.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `rst_n` is low, the status register reads 0x01 and both `sys_rst_n` and `wdt_rst_n` are low. After `rst_n` rises, both outputs stay low for 8 more clock edges and go high at the 8th edge.
- R2: A read at offset 0x230 returns the 4 cause flags in bits 3..0 with bits 7..4 as zero. A read at any other offset, including the clear offset 0x234, returns 0.
- R3: A pulse on `ext_req` sets flag bit 3 and a pulse on `wdog_req` sets flag bit 1, both at the edge that samples the pulse. Flags that were already set stay set.
- R4: A write to offset 0x234 clears every flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R5: A write to offset 0x230 with data bit 2 set starts a software reset one cycle after the write edge: flag bit 2 is set and `sys_rst_n` falls at that next edge. A write to 0x230 with data bit 2 clear changes neither the flags nor the reset outputs.
- R6: While flag bit 2 is set, a write to 0x234 with data bit 2 clear starts another software reset one cycle later, and it still clears the other flags it selects. A clear write with data bit 2 set starts no reset.
- R7: Each external, watchdog or software firing drives `sys_rst_n` low from the firing edge for exactly 8 cycles. A new firing during the pulse restarts the 8-cycle count.
- R8: `wdt_rst_n` is driven only by power-on. External, watchdog and software resets never pull it low.
- R9: Sources that fire in the same cycle all set their flags together. A flag that is set and cleared at the same edge ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| ext_req | input | 1 | External reset request pulse |
| wdog_req | input | 1 | Watchdog expiry pulse |
| reg_addr | input | ADDR_W | Register offset |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| sys_rst_n | output | 1 | System reset, active low |
| wdt_rst_n | output | 1 | Watchdog-domain reset, active low |

## Verification
The assertions assume three things about the inputs:
- `ext_req` and `wdog_req` are clean synchronous pulses.
- `reg_addr` is stable through the cycle in which the read result is observed.
- A firing that the property waits for is not cut short by a new power-on reset.

The stimulus drives every input once per cycle, half a period away from the active edge. It raises the request pulses for single cycles at random. It draws addresses mostly from the two register offsets, and it asserts `rst_n` only through a dedicated task that the model tracks.

// File: rtl/rcc_pkg.sv
// Package for the reset cause controller.
// Holds the flag positions and the flag vector type used by every module.
// Assumes the cause flags are 4 bits wide.
package rcc_pkg;
    localparam int unsigned FLAG_W   = 4;
    localparam int unsigned FLAG_POR = 0;
    localparam int unsigned FLAG_WDG = 1;
    localparam int unsigned FLAG_SW  = 2;
    localparam int unsigned FLAG_EXT = 3;

    typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/rcc_stretch.sv
// Reset pulse stretcher.
// It asserts 'active' at the edge where 'fire' is sampled high and holds it for HOLD cycles.
// A new firing during the pulse restarts the count.
// While rst_n is low the output is held active, and it stays active for HOLD edges after release.
// Assumes HOLD >= 1.
module rcc_stretch #(
    parameter int unsigned HOLD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);
    localparam int unsigned CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             act_q;

    // Load the counter on reset or on a firing, count down, then release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= LOAD;
            act_q <= 1'b1;
        end else if (fire) begin
            cnt_q <= LOAD;
            act_q <= 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else begin
            act_q <= 1'b0;
        end
    end

    assign active = act_q;
endmodule

// File: rtl/rcc_bus_dec.sv
// Register port decoder for the reset cause controller.
// It turns a write into a status-write or clear-write strobe and gives the clear mask.
// It builds the read data: the flags at the status offset and zero at every other offset.
// Assumes DATA_W >= FLAG_W.
module rcc_bus_dec
    import rcc_pkg::*;
#(
    parameter int unsigned          ADDR_W   = 12,
    parameter int unsigned          DATA_W   = 8,
    parameter logic [ADDR_W-1:0]    STAT_OFS = 12'h230,
    parameter logic [ADDR_W-1:0]    CLR_OFS  = 12'h234
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  flag_vec_t         flags,
    output logic              stat_wr,
    output logic              clr_wr,
    output logic              soft_bit,
    output flag_vec_t         clr_mask,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned PAD_W = DATA_W - FLAG_W;

    // Decode the write strobes.
    always_comb begin
        stat_wr  = we && (addr == STAT_OFS);
        clr_wr   = we && (addr == CLR_OFS);
        soft_bit = wdata[FLAG_SW];
        clr_mask = clr_wr ? wdata[FLAG_W-1:0] : '0;
    end

    // Read mux: only the status offset returns data.
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb rdata = (addr == STAT_OFS) ? {{PAD_W{1'b0}}, flags} : '0;
        end else begin : g_nopad
            always_comb rdata = (addr == STAT_OFS) ? flags : '0;
        end
    endgenerate
endmodule

// File: rtl/rcc_soft_trig.sv
// Software reset trigger.
// It registers a request one cycle after either of two writes:
// a status write with the software bit set, or a clear write that leaves the software flag set while it is already set.
// The registered request is the software firing.
module rcc_soft_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_wr,
    input  logic clr_wr,
    input  logic soft_bit,
    input  logic soft_flag,
    output logic soft_fire
);
    logic req;
    logic fire_q;

    // Find the writes that call for a software reset.
    always_comb begin
        req = (stat_wr && soft_bit) || (clr_wr && soft_flag && !soft_bit);
    end

    // Delay the request by one cycle so it fires after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) fire_q <= 1'b0;
        else        fire_q <= req;
    end

    assign soft_fire = fire_q;
endmodule

// File: rtl/rcc_status.sv
// Cause flag register.
// Power-on loads only the power-on flag.
// At each edge the flags selected by the clear mask are dropped and then the set vector is merged in, so a set wins over a clear.
module rcc_status
    import rcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t set_vec,
    input  flag_vec_t clr_mask,
    output flag_vec_t flags
);
    flag_vec_t flags_q;

    // Clear the selected flags, then set the firing sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q          <= '0;
            flags_q[FLAG_POR] <= 1'b1;
        end else begin
            flags_q <= (flags_q & ~clr_mask) | set_vec;
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/rst_cause_ctrl.sv
// Reset cause controller (top).
// It merges external, watchdog and software reset sources into a stretched system reset.
// It keeps cause flags behind a small register port.
// It drives a watchdog-domain reset that only power-on (rst_n) asserts.
// Assumes the request inputs are synchronous single-cycle pulses.
module rst_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 12,
    parameter int unsigned       DATA_W   = 8,
    parameter logic [ADDR_W-1:0] STAT_OFS = 12'h230,
    parameter logic [ADDR_W-1:0] CLR_OFS  = 12'h234,
    parameter int unsigned       HOLD     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_req,
    input  logic              wdog_req,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sys_rst_n,
    output logic              wdt_rst_n
);
    localparam int unsigned N_DOM = 2;

    flag_vec_t        status_q;
    flag_vec_t        clr_mask;
    flag_vec_t        set_vec;
    logic             stat_wr;
    logic             clr_wr;
    logic             soft_bit;
    logic             soft_fire;
    logic [N_DOM-1:0] dom_fire;
    logic [N_DOM-1:0] dom_act;

    rcc_bus_dec #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_OFS(STAT_OFS), .CLR_OFS(CLR_OFS)
    ) u_dec (
        .addr(reg_addr), .we(reg_we), .wdata(reg_wdata), .flags(status_q),
        .stat_wr(stat_wr), .clr_wr(clr_wr), .soft_bit(soft_bit),
        .clr_mask(clr_mask), .rdata(reg_rdata)
    );

    rcc_soft_trig u_soft (
        .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .clr_wr(clr_wr),
        .soft_bit(soft_bit), .soft_flag(status_q[FLAG_SW]), .soft_fire(soft_fire)
    );

    // Build the set vector from the sources that fire this cycle.
    always_comb begin
        set_vec           = '0;
        set_vec[FLAG_WDG] = wdog_req;
        set_vec[FLAG_SW]  = soft_fire;
        set_vec[FLAG_EXT] = ext_req;
    end

    rcc_status u_stat (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_mask(clr_mask), .flags(status_q)
    );

    // Domain 0 is the system reset; domain 1 is the watchdog domain, which only power-on resets.
    always_comb begin
        dom_fire[0] = ext_req | wdog_req | soft_fire;
        dom_fire[1] = 1'b0;
    end

    // One stretcher per reset domain.
    generate
        for (genvar d = 0; d < N_DOM; d++) begin : g_dom
            rcc_stretch #(.HOLD(HOLD)) u_str (
                .clk(clk), .rst_n(rst_n), .fire(dom_fire[d]), .active(dom_act[d])
            );
        end
    endgenerate

    assign sys_rst_n = ~dom_act[0];
    assign wdt_rst_n = ~dom_act[1];
endmodule

// File: rtl/rcc_checker.sv
// Assertion checker for the reset cause controller.
// It is bound to every instance of rst_cause_ctrl and observes the ports and the flag register.
module rcc_checker #(
    parameter int unsigned       ADDR_W   = 12,
    parameter int unsigned       DATA_W   = 8,
    parameter logic [ADDR_W-1:0] STAT_OFS = 12'h230,
    parameter logic [ADDR_W-1:0] CLR_OFS  = 12'h234
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_req,
    input logic              wdog_req,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              sys_rst_n,
    input logic              wdt_rst_n,
    input logic [3:0]        status
);
    // R2: the upper read bits are always zero.
    p_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:4] == '0);

    // R2: the clear offset reads back as zero.
    p_clr_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == CLR_OFS) |-> (reg_rdata == '0));

    // R3: an external pulse sets flag bit 3.
    p_ext_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |=> status[3]);

    // R3: a watchdog pulse sets flag bit 1.
    p_wdg_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_req |=> status[1]);

    // R4: clearing the power-on flag removes it; nothing but power-on sets it again.
    p_por_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == CLR_OFS && reg_wdata[0]) |=> !status[0]);

    // R5: a status write with bit 2 set pulls the system reset one cycle later.
    p_soft_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == STAT_OFS && reg_wdata[2]) |=> ##1 !sys_rst_n);

    // R6: a clear write that keeps the software flag set triggers again.
    p_retrigger_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == CLR_OFS && status[2] && !reg_wdata[2]) |=> ##1 !sys_rst_n);

    // R7: a hardware source pulls the system reset at its own edge.
    p_hw_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req || wdog_req) |=> !sys_rst_n);

    // R8: once released, the watchdog-domain reset stays released until power-on.
    p_wdt_only_por_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_n |=> wdt_rst_n);
endmodule

bind rst_cause_ctrl rcc_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_OFS(STAT_OFS), .CLR_OFS(CLR_OFS)
) u_rcc_checker (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .wdog_req(wdog_req),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sys_rst_n(sys_rst_n), .wdt_rst_n(wdt_rst_n),
    .status(status_q)
);

// File: tb/test_rst_cause_ctrl.sv
// Self-checking bench for rst_cause_ctrl.
// A cycle model built from the requirements predicts every output.
// Directed corner cases run first, then random traffic from a fixed seed.
module test_rst_cause_ctrl;
    localparam int  CLK_PERIOD = 10;
    localparam logic [11:0] STAT = 12'h230;
    localparam logic [11:0] CLR  = 12'h234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_req = 1'b0;
    logic        wdog_req = 1'b0;
    logic [11:0] reg_addr = STAT;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        sys_rst_n;
    logic        wdt_rst_n;

    int checks = 0;
    int errors = 0;

    // Model state.
    logic [3:0] m_stat;
    logic       m_swq;
    int         m_cnt;
    int         m_wcnt;

    rst_cause_ctrl i_rst_cause_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .wdog_req(wdog_req),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sys_rst_n(sys_rst_n), .wdt_rst_n(wdt_rst_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_read(input logic [11:0] a, input logic [3:0] s);
        return (a == STAT) ? {4'b0000, s} : 8'h00;
    endfunction

    function automatic logic [3:0] next_flags(input logic [3:0] s, input logic [3:0] clr,
                                              input logic [3:0] set);
        return (s & ~clr) | set;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_ports(input string rtag, input string stag);
        chk(rtag, reg_rdata, exp_read(reg_addr, m_stat));
        chk(stag, {7'd0, sys_rst_n}, {7'd0, m_cnt == 0});
        chk("R8", {7'd0, wdt_rst_n}, {7'd0, m_wcnt == 0});
    endtask

    // One clock: drive at the negedge, advance the model over the edge, check at the next negedge.
    task automatic cycle(input logic e, input logic w, input logic [11:0] a,
                         input logic we_i, input logic [7:0] d, input string tag);
        logic       fire_sw;
        logic [3:0] clr;
        logic [3:0] set;
        ext_req = e; wdog_req = w; reg_addr = a; reg_we = we_i; reg_wdata = d;
        fire_sw = m_swq;
        m_swq = we_i && ((a == STAT && d[2]) || (a == CLR && m_stat[2] && !d[2]));
        clr = (we_i && a == CLR) ? d[3:0] : 4'h0;
        set = {e, fire_sw, w, 1'b0};
        m_stat = next_flags(m_stat, clr, set);
        if (e || w || fire_sw) m_cnt = 8;
        else if (m_cnt > 0) m_cnt--;
        if (m_wcnt > 0) m_wcnt--;
        @(negedge clk);
        check_ports(tag, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, STAT, 1'b0, 8'h00, "R7");
    endtask

    task automatic power_on;
        rst_n = 1'b0;
        reg_we = 1'b0; ext_req = 1'b0; wdog_req = 1'b0; reg_addr = STAT;
        m_stat = 4'h1; m_swq = 1'b0; m_cnt = 8; m_wcnt = 8;
        repeat (3) @(negedge clk);
        // R1: state during power-on.
        chk("R1", reg_rdata, 8'h01);
        chk("R1", {7'd0, sys_rst_n}, 8'h00);
        chk("R1", {7'd0, wdt_rst_n}, 8'h00);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        power_on();
        // R1: low for 7 more edges, high at the 8th.
        idle(7);
        chk("R1", {7'd0, sys_rst_n}, 8'h00);
        idle(1);
        chk("R1", {7'd0, sys_rst_n & wdt_rst_n}, 8'h01);

        // R3: the external and watchdog pulses set their flags and keep the old ones.
        cycle(1'b1, 1'b0, STAT, 1'b0, 8'h00, "R3");
        chk("R3", reg_rdata, 8'h09);
        idle(8);
        cycle(1'b0, 1'b1, STAT, 1'b0, 8'h00, "R3");
        chk("R3", reg_rdata, 8'h0B);
        idle(9);

        // R4: clear selected flags; R2: the clear offset reads zero.
        cycle(1'b0, 1'b0, CLR, 1'b1, 8'h01, "R2");
        chk("R2", reg_rdata, 8'h00);
        cycle(1'b0, 1'b0, STAT, 1'b0, 8'h00, "R4");
        chk("R4", reg_rdata, 8'h0A);

        // R5: a status write with bit 2 clear has no effect.
        cycle(1'b0, 1'b0, STAT, 1'b1, 8'hFB, "R5");
        cycle(1'b0, 1'b0, STAT, 1'b0, 8'h00, "R5");
        chk("R5", {reg_rdata[3:0], 3'd0, sys_rst_n}, {4'hA, 4'h1});

        // R5: a software reset starts one cycle after the write.
        cycle(1'b0, 1'b0, STAT, 1'b1, 8'h04, "R5");
        chk("R5", {7'd0, sys_rst_n}, 8'h01);
        cycle(1'b0, 1'b0, STAT, 1'b0, 8'h00, "R5");
        chk("R5", {reg_rdata[3:0], 3'd0, sys_rst_n}, {4'hE, 4'h0});
        idle(9);

        // R6: a clear that leaves bit 2 set triggers again and still clears bit 1.
        cycle(1'b0, 1'b0, CLR, 1'b1, 8'h02, "R6");
        cycle(1'b0, 1'b0, STAT, 1'b0, 8'h00, "R6");
        chk("R6", {reg_rdata[3:0], 3'd0, sys_rst_n}, {4'hC, 4'h0});
        idle(9);
        // R6: clearing bit 2 starts no reset.
        cycle(1'b0, 1'b0, CLR, 1'b1, 8'h04, "R6");
        cycle(1'b0, 1'b0, STAT, 1'b0, 8'h00, "R6");
        chk("R6", {reg_rdata[3:0], 3'd0, sys_rst_n}, {4'h8, 4'h1});

        // R9: simultaneous sources together with a full clear; the sets win.
        cycle(1'b1, 1'b1, CLR, 1'b1, 8'h0F, "R9");
        cycle(1'b0, 1'b0, STAT, 1'b0, 8'h00, "R9");
        chk("R9", reg_rdata, 8'h0A);
        // R7: a refire in the middle of the pulse restarts the count.
        idle(4);
        cycle(1'b0, 1'b1, STAT, 1'b0, 8'h00, "R7");
        idle(7);
        chk("R7", {7'd0, sys_rst_n}, 8'h00);
        idle(1);
        chk("R7", {7'd0, sys_rst_n}, 8'h01);
        // R8: the watchdog domain was never touched.
        chk("R8", {7'd0, wdt_rst_n}, 8'h01);

        // Random traffic.
        for (int i = 0; i < 4000; i++) begin
            logic [11:0] a;
            int          sel;
            sel = $urandom_range(0, 9);
            a = (sel < 4) ? STAT : (sel < 8) ? CLR : 12'($urandom_range(0, 4095));
            cycle(($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0), a,
                  ($urandom_range(0, 2) == 0), 8'($urandom_range(0, 255)), "R2");
        end

        // R1: power-on in the middle of the run reloads only flag bit 0.
        cycle(1'b1, 1'b1, STAT, 1'b0, 8'h00, "R9");
        power_on();
        idle(10);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule